// File: doc/BRIEF.md
# Descriptor Admission Checker

This block sits beside a DMA channel's descriptor fetch path. The fetched descriptor arrives as a stream of sixteen 32-bit words, one word per accepted beat. When the final word arrives, the block decides whether the channel may act on the descriptor. If it may not, the block names the first rule the descriptor breaks. It also forms the status word that the channel publishes for that descriptor, and it flags whether this descriptor closes the chain.

The input is a valid/ready stream. A beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle: the cycle in which a verdict is presented. A producer may hold `in_valid` and `in_data` steady across that cycle, and the held beat is taken on the following edge. The verdict has no back-pressure. It is a single-cycle pulse, and the consumer must capture it in that cycle. A channel tag travels with the first word and is returned with the verdict, so one checker can serve several channels in turn.

Word 0 is the control word. Bit 31 of word 5 is the completion flag. Words 0 to 14 are covered by the checksum, and word 15 carries the expected checksum.

Top module: `desc_guard`

## Requirements
- R1: A beat is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low only in a cycle where `res_valid` is high, and a beat offered in that cycle is not taken.
- R2: `res_valid` is high for exactly the one cycle that follows the edge accepting the sixteenth word of a descriptor, and is low otherwise.
- R3: When control bits [7:0] differ from 0xA5, `res_err` is 1 (format error) and `res_ok` is 0.
- R4: When control bit 20 is set, the 32-bit wrapping sum of words 0 to 14 must equal word 15. A mismatch gives `res_err` 2 (checksum error).
- R5: When control bit 20 is clear, word 15 has no effect on the verdict.
- R6: When word 5 bit 31 is set and control bit 10 is clear, `res_err` is 3 (already consumed). When control bit 10 is set, the completion flag causes no error.
- R7: Only the first failing rule is reported, in the order format, then checksum, then completion flag. `res_err` is 0 and `res_ok` is 1 exactly when no rule fails.
- R8: `res_status` holds control[7:0] at bits [20:13], together with these flags:
  - bit 12 = control bit 8
  - bit 11 = control bit 9
  - bit 10 = completion flag
  - bit 9 = control bit 10
  - bit 8 = control bit 21
  - bit 7 = control bit 19
  - bit 6 = control bit 20
  - bit 5 = control bit 18
  - bit 4 = control bit 11

  All other status bits are zero. The status word is formed whatever the verdict.
- R9: `res_last` is high when control bit 19 or control bit 21 is set.
- R10: After a verdict, the next accepted word is treated as word 0 of a new descriptor. The checksum and captured fields start afresh.
- R11: While reset is active and just after it, `res_valid` is 0, `in_ready` is 1, and `res_err` is 0.
- R12: `res_chan` returns the `in_chan` value that was present when word 0 was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor word offered |
| in_ready | output | 1 | Checker can take a word |
| in_data | input | WORD_W | Descriptor word |
| in_chan | input | CHAN_W | Channel tag, sampled with word 0 |
| res_valid | output | 1 | Verdict pulse |
| res_ok | output | 1 | Descriptor may be processed |
| res_err | output | 2 | 0 none, 1 format, 2 checksum, 3 already consumed |
| res_last | output | 1 | Descriptor ends the chain |
| res_chan | output | CHAN_W | Channel tag of this verdict |
| res_status | output | 32 | Channel status word |

## Verification
A beat counter that is out of step shows up at once. The verdict pulse arrives after the wrong number of beats, or a descriptor is checked against fields from the wrong word. That makes checksum and format verdicts wrong on the very next descriptor. An accumulator that does not restart, or a stale captured control word or completion flag, corrupts `res_err` or `res_status` on the descriptor that follows. A stuck ready or pulse shows as a beat swallowed during the verdict cycle, and every later verdict is then misaligned.

// File: rtl/desc_guard_pkg.sv
package desc_guard_pkg;
  localparam logic [7:0] FORMAT_KEY = 8'hA5;

  localparam int CB_IRQ_EN   = 8;
  localparam int CB_WB_EN    = 9;
  localparam int CB_IGN_DONE = 10;
  localparam int CB_BURST    = 11;
  localparam int CB_FRAGMODE = 18;
  localparam int CB_CHAIN_END= 19;
  localparam int CB_SUM_EN   = 20;
  localparam int CB_FRAME_END= 21;

  localparam int FLAG_WORD = 5;
  localparam int FLAG_BIT  = 31;

  typedef enum logic [1:0] {
    VERDICT_PASS     = 2'd0,
    VERDICT_FORMAT   = 2'd1,
    VERDICT_CHECKSUM = 2'd2,
    VERDICT_CONSUMED = 2'd3
  } verdict_e;
endpackage

// File: rtl/dg_beat_counter.sv
module dg_beat_counter #(
  parameter int N_WORDS = 16,
  localparam int IDX_W = $clog2(N_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [IDX_W-1:0] idx,
  output logic             at_first,
  output logic             at_final
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (take) begin
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end
  end

  assign at_first = (idx == '0);
  assign at_final = (idx == LAST_IDX);
endmodule

// File: rtl/dg_sum_accum.sv
module dg_sum_accum #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              at_first,
  input  logic              at_final,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] partial
);
  // partial holds the wrapping sum of every word before the current one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      partial <= '0;
    end else if (take && !at_final) begin
      partial <= at_first ? data : partial + data;
    end
  end
endmodule

// File: rtl/dg_field_latch.sv
module dg_field_latch
  import desc_guard_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_WORDS = 16,
  parameter int CHAN_W = 3,
  localparam int IDX_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data,
  input  logic [CHAN_W-1:0] chan,
  output logic [WORD_W-1:0] ctrl,
  output logic              consumed,
  output logic [CHAN_W-1:0] tag
);
  localparam logic [IDX_W-1:0] FLAG_IDX = IDX_W'(FLAG_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      consumed <= 1'b0;
      tag      <= '0;
    end else if (take) begin
      if (idx == '0) begin
        ctrl <= data;
        tag  <= chan;
      end
      if (idx == FLAG_IDX) begin
        consumed <= data[FLAG_BIT];
      end
    end
  end
endmodule

// File: rtl/dg_verdict.sv
module dg_verdict
  import desc_guard_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] ctrl,
  input  logic              consumed,
  input  logic [WORD_W-1:0] partial,
  input  logic [WORD_W-1:0] expect_sum,
  output verdict_e          verdict,
  output logic [31:0]       status,
  output logic              chain_end
);
  logic fmt_bad, sum_bad, flag_bad;

  always_comb begin
    fmt_bad  = (ctrl[7:0] != FORMAT_KEY);
    sum_bad  = ctrl[CB_SUM_EN] && (partial != expect_sum);
    flag_bad = consumed && !ctrl[CB_IGN_DONE];
    if (fmt_bad)       verdict = VERDICT_FORMAT;
    else if (sum_bad)  verdict = VERDICT_CHECKSUM;
    else if (flag_bad) verdict = VERDICT_CONSUMED;
    else               verdict = VERDICT_PASS;
  end

  always_comb begin
    status        = '0;
    status[20:13] = ctrl[7:0];
    status[12]    = ctrl[CB_IRQ_EN];
    status[11]    = ctrl[CB_WB_EN];
    status[10]    = consumed;
    status[9]     = ctrl[CB_IGN_DONE];
    status[8]     = ctrl[CB_FRAME_END];
    status[7]     = ctrl[CB_CHAIN_END];
    status[6]     = ctrl[CB_SUM_EN];
    status[5]     = ctrl[CB_FRAGMODE];
    status[4]     = ctrl[CB_BURST];
  end

  assign chain_end = ctrl[CB_CHAIN_END] | ctrl[CB_FRAME_END];
endmodule

// File: rtl/desc_guard.sv
module desc_guard
  import desc_guard_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 16,
  parameter int CHAN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CHAN_W-1:0] in_chan,
  output logic              res_valid,
  output logic              res_ok,
  output logic [1:0]        res_err,
  output logic              res_last,
  output logic [CHAN_W-1:0] res_chan,
  output logic [31:0]       res_status
);
  localparam int IDX_W = $clog2(N_WORDS);

  logic              take, at_first, at_final;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] partial, ctrl;
  logic              consumed;
  logic [CHAN_W-1:0] tag;
  verdict_e          verdict;
  logic [31:0]       status;
  logic              chain_end;

  assign in_ready = !res_valid;
  assign take     = in_valid && in_ready;

  dg_beat_counter #(.N_WORDS(N_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .take(take),
    .idx(idx), .at_first(at_first), .at_final(at_final)
  );

  dg_sum_accum #(.WORD_W(WORD_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .take(take), .at_first(at_first),
    .at_final(at_final), .data(in_data), .partial(partial)
  );

  dg_field_latch #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .CHAN_W(CHAN_W)) u_fld (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data),
    .chan(in_chan), .ctrl(ctrl), .consumed(consumed), .tag(tag)
  );

  dg_verdict #(.WORD_W(WORD_W)) u_vrd (
    .ctrl(ctrl), .consumed(consumed), .partial(partial),
    .expect_sum(in_data), .verdict(verdict), .status(status),
    .chain_end(chain_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_ok     <= 1'b0;
      res_err    <= 2'd0;
      res_last   <= 1'b0;
      res_chan   <= '0;
      res_status <= '0;
    end else begin
      res_valid <= take && at_final;
      if (take && at_final) begin
        res_ok     <= (verdict == VERDICT_PASS);
        res_err    <= verdict;
        res_last   <= chain_end;
        res_chan   <= tag;
        res_status <= status;
      end
    end
  end
endmodule

// File: rtl/desc_guard_chk.sv
module desc_guard_chk #(
  parameter int N_WORDS = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        res_valid,
  input logic        res_ok,
  input logic [1:0]  res_err,
  input logic        res_last,
  input logic [31:0] res_status
);
  localparam int CW = $clog2(N_WORDS);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && in_ready)
      seen <= (seen == CW'(N_WORDS - 1)) ? '0 : seen + 1'b1;
  end

  // R1: ready only drops while a verdict is shown
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> res_valid);
  // R2: verdict follows the final beat and lasts one cycle
  p_pulse_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready && seen == CW'(N_WORDS - 1)));
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R3: bad format key always gives the format verdict
  p_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status[20:13] != 8'hA5) |-> (res_err == 2'd1));
  // R6: consumed verdict only with flag set and override clear
  p_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err == 2'd3) |-> (res_status[10] && !res_status[9]));
  // R7: ok agrees with the verdict code
  p_ok_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ok == (res_err == 2'd0)));
  // R9: chain end mirrors the two end markers in the status word
  p_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_last == (res_status[7] | res_status[8])));
endmodule

bind desc_guard desc_guard_chk #(.N_WORDS(N_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ok(res_ok), .res_err(res_err),
  .res_last(res_last), .res_status(res_status)
);

// File: tb/desc_guard_tb.sv
module desc_guard_tb;
  localparam int PERIOD = 10;
  localparam int SEED   = 32'h5EED_2024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  in_chan = '0;
  logic        res_valid, res_ok, res_last;
  logic [1:0]  res_err;
  logic [2:0]  res_chan;
  logic [31:0] res_status;

  int checks = 0;
  int fails  = 0;
  logic [31:0] d [16];

  always #(PERIOD/2) clk = ~clk;

  desc_guard u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .res_valid(res_valid),
    .res_ok(res_ok), .res_err(res_err), .res_last(res_last),
    .res_chan(res_chan), .res_status(res_status)
  );

  task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sum15();
    logic [31:0] s = '0;
    for (int i = 0; i < 15; i++) s = s + d[i];
    return s;
  endfunction

  function automatic logic [1:0] exp_err();
    if (d[0][7:0] != 8'hA5) return 2'd1;
    if (d[0][20] && sum15() != d[15]) return 2'd2;
    if (d[5][31] && !d[0][10]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[20:13] = d[0][7:0];
    s[12] = d[0][8];  s[11] = d[0][9];  s[10] = d[5][31];
    s[9]  = d[0][10]; s[8]  = d[0][21]; s[7]  = d[0][19];
    s[6]  = d[0][20]; s[5]  = d[0][18]; s[4]  = d[0][11];
    return s;
  endfunction

  task automatic fill(input bit key_ok, input bit sum_en, input bit sum_ok,
                      input bit flag, input bit ign);
    for (int i = 0; i < 16; i++) d[i] = $urandom;
    d[0][20] = sum_en;
    d[0][10] = ign;
    if (key_ok) d[0][7:0] = 8'hA5;
    else if (d[0][7:0] == 8'hA5) d[0][7:0] = 8'h5A;
    d[5][31] = flag;
    d[15] = sum_ok ? sum15() : sum15() ^ 32'h0000_0100;
  endtask

  // drives one descriptor, holds a junk beat in the verdict cycle, checks
  task automatic send(input int max_gap, input string tag);
    logic [2:0] ch = 3'($urandom);
    logic [1:0] e = exp_err();
    logic [31:0] st = exp_status();
    for (int i = 0; i < 16; i++) begin
      int gap = (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = d[i];
      in_chan  = (i == 0) ? ch : 3'($urandom);
      @(posedge clk);
    end
    @(negedge clk);
    chk(res_valid == 1'b1, {tag, " R2 pulse"}, 32'(res_valid), 1);
    chk(in_ready == 1'b0, {tag, " R1 ready low"}, 32'(in_ready), 0);
    chk(res_err == e, {tag, " R3/R4/R6/R7 verdict"}, 32'(res_err), 32'(e));
    chk(res_ok == (e == 2'd0), {tag, " R7 ok"}, 32'(res_ok), 32'(e == 2'd0));
    chk(res_status == st, {tag, " R8 status"}, res_status, st);
    chk(res_last == (d[0][19] | d[0][21]), {tag, " R9 last"}, 32'(res_last),
        32'(d[0][19] | d[0][21]));
    chk(res_chan == ch, {tag, " R12 chan"}, 32'(res_chan), 32'(ch));
    in_valid = 1'b1;
    in_data  = 32'hDEAD_0000;
    @(negedge clk);
    chk(res_valid == 1'b0, {tag, " R2 single"}, 32'(res_valid), 0);
    chk(in_ready == 1'b1, {tag, " R1 ready back"}, 32'(in_ready), 1);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R11 reset valid", 32'(res_valid), 0);
    chk(in_ready == 1'b1, "R11 reset ready", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_err == 2'd0, "R11 err after reset", 32'(res_err), 0);
    chk(res_valid == 1'b0, "R11 valid after reset", 32'(res_valid), 0);

    fill(1, 1, 1, 0, 0); send(0, "R4 good sum");
    fill(0, 1, 0, 1, 0); send(1, "R7 format first");
    fill(1, 1, 0, 1, 0); send(1, "R7 checksum before flag");
    fill(1, 0, 0, 0, 0); send(0, "R5 sum disabled");
    fill(1, 0, 1, 1, 1); send(2, "R6 flag ignored");
    fill(1, 0, 1, 1, 0); send(0, "R6 flag error");
    for (int i = 0; i < 16; i++) d[i] = 32'hFFFF_FFF0 + 32'(i);
    d[0] = 32'h0010_00A5 | 32'h0028_0000; d[5][31] = 1'b0;
    d[15] = sum15();
    send(0, "R4 wrap sum");
    fill(1, 0, 1, 0, 0); d[0][19] = 1'b0; d[0][21] = 1'b1; send(0, "R9 frame end");
    fill(1, 0, 1, 0, 0); d[0][19] = 1'b0; d[0][21] = 1'b0; send(0, "R9 no end");
    for (int n = 0; n < 300; n++) begin
      fill(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2);
      send(2, "R10 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule